// File: doc/BRIEF.md
# Bus-Cycle-Aligned Reset Controller

This block turns an asynchronous, active-low external reset request into an internal reset for the processor core and peripherals. The request pin is seen only through a clocked synchronizer, so nothing happens while the clock is stopped. Once the request is qualified, the block does not cut into a bus transfer. If a bus cycle is running, the internal reset waits until that cycle ends, so a write that has already started always completes intact.

The internal reset stays high for a minimum number of clocks and for as long as the synchronized pin stays low. When it drops, the block raises a single-clock reset exception request to the CPU. This request outranks every other exception and carries no resume state. In the last clock of the reset, the block captures the hardware mode-select inputs. It holds that configuration until the next reset completes.

Top module: `bus_reset_ctrl`

## Requirements
- R1: While rst_ni is low, core_rst_o and rst_exc_o are 0 and mode_cfg_o is 0. The synchronized view of the pin starts in the released (high) state.
- R2: A request counts only after two consecutive synchronized low samples. A low on ext_rst_ni seen by a single rising edge causes no reset.
- R3: With bus_active_i low, core_rst_o rises after the fourth rising edge, counting the first edge that samples ext_rst_ni low as the first.
- R4: If a bus cycle is active when the request is recognized, core_rst_o stays 0 until cycle_done_i is high or bus_active_i is low at a rising edge. It rises after that edge.
- R5: Once high, core_rst_o stays high for at least MIN_HOLD (16) clocks.
- R6: core_rst_o stays high while the synchronized pin is low. It falls after the third rising edge that samples ext_rst_ni high, once R5 is met.
- R7: rst_exc_o is high for exactly the one clock that follows the fall of core_rst_o, and at no other time.
- R8: mode_cfg_o takes the value of mode_sel_i from the last clock in which core_rst_o is high. It then ignores mode_sel_i until the next release.
- R9: A recognized request is committed. Releasing the pin while the block waits for the bus cycle to end does not cancel the internal reset.
- R10: While the clock is stopped, a low on ext_rst_ni has no effect. The reset follows the R3 timing once edges resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block's own state |
| ext_rst_ni | input | 1 | External reset request pin, active low, asynchronous |
| bus_active_i | input | 1 | A bus cycle is in progress |
| cycle_done_i | input | 1 | Strobe marking the final clock of the current bus cycle |
| mode_sel_i | input | MODE_W | Hardware mode-select inputs |
| core_rst_o | output | 1 | Internal reset to core and peripherals, active high |
| rst_exc_o | output | 1 | One-clock reset exception request to the CPU |
| mode_cfg_o | output | MODE_W | Mode-select value captured at the end of reset |

## Verification
The hardest case to reach is a request that is recognized while a bus cycle is still open, with the pin released before the cycle ends. The stimulus holds bus_active_i high and keeps the pin low just long enough for qualification. It then raises the pin and only later issues cycle_done_i, to show that the reset still fires. A second hard case is a stopped clock. The bench halts its own clock generator, drops the pin, confirms the outputs stay quiet, then restarts the clock and measures the rise latency.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2,
    ST_EXC  = 2'd3
  } brc_state_e;
endpackage

// File: rtl/brc_pin_sync.sv
module brc_pin_sync #(
  parameter int SYNC_STAGES  = 2,
  parameter int QUAL_SAMPLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic pin_high_o,
  output logic req_o
);
  localparam int HW = QUAL_SAMPLES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [HW-1:0]          hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_ni};
  end

  // older synchronized samples used for qualification
  generate
    if (HW == 1) begin : g_hist_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '1;
        else         hist_q <= sync_q[SYNC_STAGES-1];
      end
    end else begin : g_hist_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '1;
        else         hist_q <= {hist_q[HW-2:0], sync_q[SYNC_STAGES-1]};
      end
    end
  endgenerate

  assign pin_high_o = sync_q[SYNC_STAGES-1];
  assign req_o      = ~sync_q[SYNC_STAGES-1] & ~(|hist_q);
endmodule

// File: rtl/brc_hold_cnt.sv
module brc_hold_cnt #(
  parameter int MIN_HOLD = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = $clog2(MIN_HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_HOLD - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q >= LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i)           cnt_q <= '0;
    else if (en_i && !done_o)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/brc_seq.sv
module brc_seq
  import brc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic pin_high_i,
  input  logic bus_active_i,
  input  logic cycle_done_i,
  input  logic hold_done_i,
  output logic core_rst_o,
  output logic exc_o,
  output logic hold_clr_o,
  output logic capture_o
);
  brc_state_e state_q, state_d;
  logic       cycle_end;
  logic       release_ok;

  assign cycle_end  = ~bus_active_i | cycle_done_i;
  assign release_ok = hold_done_i & pin_high_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i) state_d = cycle_end ? ST_HOLD : ST_WAIT;
      ST_WAIT: if (cycle_end) state_d = ST_HOLD;   // committed, pin ignored
      ST_HOLD: if (release_ok) state_d = ST_EXC;
      ST_EXC:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign core_rst_o = (state_q == ST_HOLD);
  assign exc_o      = (state_q == ST_EXC);
  assign hold_clr_o = (state_q != ST_HOLD);
  assign capture_o  = (state_q == ST_HOLD) & release_ok;
endmodule

// File: rtl/brc_mode_latch.sv
module brc_mode_latch #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         capture_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q_o <= '0;
    else if (capture_i) q_o <= d_i;
  end
endmodule

// File: rtl/bus_reset_ctrl.sv
module bus_reset_ctrl #(
  parameter int SYNC_STAGES  = 2,
  parameter int QUAL_SAMPLES = 2,
  parameter int MIN_HOLD     = 16,
  parameter int MODE_W       = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_rst_ni,
  input  logic              bus_active_i,
  input  logic              cycle_done_i,
  input  logic [MODE_W-1:0] mode_sel_i,
  output logic              core_rst_o,
  output logic              rst_exc_o,
  output logic [MODE_W-1:0] mode_cfg_o
);
  logic pin_high, req, hold_done, hold_clr, capture;

  brc_pin_sync #(
    .SYNC_STAGES (SYNC_STAGES),
    .QUAL_SAMPLES(QUAL_SAMPLES)
  ) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_ni    (ext_rst_ni),
    .pin_high_o(pin_high),
    .req_o     (req)
  );

  brc_hold_cnt #(.MIN_HOLD(MIN_HOLD)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(hold_clr),
    .en_i   (core_rst_o),
    .done_o (hold_done)
  );

  brc_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req),
    .pin_high_i  (pin_high),
    .bus_active_i(bus_active_i),
    .cycle_done_i(cycle_done_i),
    .hold_done_i (hold_done),
    .core_rst_o  (core_rst_o),
    .exc_o       (rst_exc_o),
    .hold_clr_o  (hold_clr),
    .capture_o   (capture)
  );

  brc_mode_latch #(.W(MODE_W)) u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture),
    .d_i      (mode_sel_i),
    .q_o      (mode_cfg_o)
  );
endmodule

// File: rtl/brc_checker.sv
module brc_checker #(
  parameter int MIN_HOLD = 16,
  parameter int MODE_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ext_rst_ni,
  input logic              bus_active_i,
  input logic              cycle_done_i,
  input logic              core_rst_o,
  input logic              rst_exc_o,
  input logic [MODE_W-1:0] mode_cfg_o
);
  localparam int CW = $clog2(MIN_HOLD + 1);
  localparam logic [CW-1:0] MAXC = CW'(MIN_HOLD);

  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hi_cnt <= '0;
    else if (!core_rst_o) hi_cnt <= '0;
    else if (hi_cnt != MAXC) hi_cnt <= hi_cnt + 1'b1;
  end

  a_r4_bus_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_rst_o) |-> $past(!bus_active_i || cycle_done_i));

  a_r5_min_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_o) |-> (hi_cnt >= MAXC));

  a_r6_pin_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_o) |-> $past(ext_rst_ni, 2));

  a_r7_exc_follows_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_o) |-> rst_exc_o);

  a_r7_exc_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_exc_o |=> !rst_exc_o);

  a_r8_mode_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(core_rst_o) |-> $stable(mode_cfg_o));
endmodule

bind bus_reset_ctrl brc_checker #(
  .MIN_HOLD(MIN_HOLD),
  .MODE_W  (MODE_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ext_rst_ni  (ext_rst_ni),
  .bus_active_i(bus_active_i),
  .cycle_done_i(cycle_done_i),
  .core_rst_o  (core_rst_o),
  .rst_exc_o   (rst_exc_o),
  .mode_cfg_o  (mode_cfg_o)
);

// File: tb/tb_bus_reset_ctrl.sv
`timescale 1ns/1ps
module tb_bus_reset_ctrl;
  localparam int MIN_HOLD = 16;
  localparam int MODE_W   = 4;

  logic clk = 1'b0;
  logic clk_run = 1'b1;
  always #2 if (clk_run) clk = ~clk;

  logic              rst_n = 1'b0;
  logic              ext_rst_n = 1'b1;
  logic              bus_act = 1'b0;
  logic              done = 1'b0;
  logic [MODE_W-1:0] mode_sel = '0;
  logic              core_rst, exc;
  logic [MODE_W-1:0] mode_cfg;

  bus_reset_ctrl #(.MIN_HOLD(MIN_HOLD), .MODE_W(MODE_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ext_rst_ni(ext_rst_n),
    .bus_active_i(bus_act), .cycle_done_i(done), .mode_sel_i(mode_sel),
    .core_rst_o(core_rst), .rst_exc_o(exc), .mode_cfg_o(mode_cfg)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: phases 0 idle, 1 waiting for bus, 2 reset, 3 exception
  logic              pin_hist[$];
  int                m_phase, m_cnt;
  logic [MODE_W-1:0] m_mode;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_hist = '{1'b1, 1'b1, 1'b1};
      m_phase = 0; m_cnt = 0; m_mode = '0;
    end else begin
      logic seen_high, qualified;
      seen_high = pin_hist[1];
      qualified = !pin_hist[1] && !pin_hist[0];
      case (m_phase)
        0: if (qualified) begin m_phase = (!bus_act || done) ? 2 : 1; m_cnt = 0; end
        1: if (!bus_act || done) begin m_phase = 2; m_cnt = 0; end
        2: if (m_cnt >= MIN_HOLD - 1 && seen_high) begin m_phase = 3; m_mode = mode_sel; end
           else m_cnt++;
        default: m_phase = 0;
      endcase
      pin_hist.push_back(ext_rst_n);
      void'(pin_hist.pop_front());
    end
  end

  int hi_run = 0, last_w = 0, exc_run = 0, last_exc_w = 0;

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk("R3 R4 R5 R6 R9 core_rst", {31'd0, core_rst}, {31'd0, m_phase == 2});
      chk("R7 rst_exc", {31'd0, exc}, {31'd0, m_phase == 3});
      chk("R8 mode_cfg", {28'd0, mode_cfg}, {28'd0, m_mode});
      if (core_rst) hi_run++;
      else if (hi_run > 0) begin last_w = hi_run; hi_run = 0; end
      if (exc) exc_run++;
      else if (exc_run > 0) begin last_exc_w = exc_run; exc_run = 0; end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic edges_to_rise(output int c);
    c = 0;
    while (!core_rst && c < 60) begin @(posedge clk); #1; c++; end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int c;
    tick(3);
    chk("R1 core_rst in reset", {31'd0, core_rst}, 32'd0);
    chk("R1 rst_exc in reset", {31'd0, exc}, 32'd0);
    chk("R1 mode_cfg in reset", {28'd0, mode_cfg}, 32'd0);
    rst_n = 1'b1;
    tick(4);

    // R2: one-edge low glitch must be ignored
    ext_rst_n = 1'b0; tick(1); ext_rst_n = 1'b1;
    tick(8);
    chk("R2 glitch ignored", {31'd0, core_rst}, 32'd0);

    // R3: idle bus, short request, minimum width
    mode_sel = 4'hA;
    @(negedge clk); ext_rst_n = 1'b0;
    edges_to_rise(c);
    chk("R3 rise latency", c, 32'd4);
    @(negedge clk); ext_rst_n = 1'b1;
    tick(24);
    chk("R5 minimum width", last_w, MIN_HOLD);
    chk("R7 exception width", last_exc_w, 32'd1);
    chk("R8 captured value", {28'd0, mode_cfg}, 32'hA);
    mode_sel = 4'h5; tick(6);
    chk("R8 ignored after release", {28'd0, mode_cfg}, 32'hA);

    // R6: long request: low for 40 edges, rise after edge 4, fall after edge 43
    ext_rst_n = 1'b0; tick(40); ext_rst_n = 1'b1;
    tick(10);
    chk("R6 width follows pin", last_w, 32'd39);
    chk("R8 second capture", {28'd0, mode_cfg}, 32'h5);

    // R4: bus cycle in progress
    bus_act = 1'b1; ext_rst_n = 1'b0; mode_sel = 4'h3;
    tick(12);
    chk("R4 held off during cycle", {31'd0, core_rst}, 32'd0);
    done = 1'b1;
    @(negedge clk);
    chk("R4 rise after cycle end", {31'd0, core_rst}, 32'd1);
    done = 1'b0; bus_act = 1'b0; ext_rst_n = 1'b1;
    tick(25);

    // R9: release while waiting for the cycle to end
    bus_act = 1'b1; ext_rst_n = 1'b0; tick(4);
    ext_rst_n = 1'b1; tick(6);
    chk("R9 still waiting", {31'd0, core_rst}, 32'd0);
    done = 1'b1;
    @(negedge clk);
    chk("R9 committed reset", {31'd0, core_rst}, 32'd1);
    done = 1'b0; bus_act = 1'b0;
    tick(25);
    chk("R9 completes", {31'd0, core_rst}, 32'd0);

    // R10: stopped clock
    clk_run = 1'b0;
    ext_rst_n = 1'b0;
    #100;
    chk("R10 no reset without clock", {31'd0, core_rst}, 32'd0);
    clk_run = 1'b1;
    edges_to_rise(c);
    chk("R10 rise latency after restart", c, 32'd4);
    @(negedge clk); ext_rst_n = 1'b1;
    tick(25);
    chk("R7 exception after restart", last_exc_w, 32'd1);

    finish_run();
  end
endmodule